// File: doc/BRIEF.md
# Codec boot and configuration sequencer

This block brings up one or two external image-compression coprocessors after a start pulse. It drives a 32-bit register bus and programs each device in a fixed order. First it sets the clock control and the boot mode. Next it sets the host and indirect-access widths and downloads a firmware image through an indirect address/data port. It then restarts the device's software and writes the bus widths a second time. After that it loads the encoding-parameter block and commits it. Last, it unmasks the software interrupt, waits for the interrupt line to fall, and confirms that the expected firmware answered.

Firmware words and the common parameter words come from a ROM-like word source with an asynchronous read. Each instance gets its own channel-type word, which picks a luma or a chroma setup. Every bus access has a parameterized setup phase, strobe width and hold phase, so the strobe rate can be kept within what the coprocessor accepts. The outcome is reported on `done`, `err` and a two-bit error code.

In sequential mode the two devices are brought up one after the other. In parallel mode the common writes go to both devices at once.

Top module: `codec_boot_seq`

## Requirements
- R1: During reset and while idle after reset, `bus_wr`, `bus_rd`, `bus_sel`, `bus_addr`, `bus_wdata`, `done`, `err` and `err_code` are all zero.
- R2: After `start`, the first four writes are, in order: clock control (address 0) with `PLL_CFG`, boot control (address 1) with 0x008A, bus width (address 2) with 0x000A, and indirect mode (address 3) with 0x000A.
- R3: Next comes a write of 0x00050000 to the indirect address (address 4). It is followed by `FW_WORDS` writes to the indirect data port (address 5), which carry the source words at `rom_addr` 0 through `FW_WORDS`-1 in ascending order.
- R4: After the firmware, boot control receives 0x008D, then bus width 0x000A, then indirect mode 0x000A.
- R5: The parameter load has four parts, in this order: indirect address 0x00057F00; the instance's channel word (`CHAN_WORD0` for instance 0, default 0x02010503; `CHAN_WORD1` for instance 1, default 0x03010503); `PRM_WORDS` source words from `rom_addr` `FW_WORDS` upward; and a terminating 0x00000000. All data words go to address 5.
- R6: The check phase begins with a write of 0x0400 to the interrupt mask (address 6). The block then waits with the bus idle until `irq_n[i]` of the instance under check is low. It then reads the interrupt status (address 7). If bit 10 of that status is clear, the run ends with error code 2.
- R7: Next the block reads the application tag (address 8). Any value other than exactly 0x0000FF82 ends the run with error code 3. If every instance passes, `done`=1 and `err`=0.
- R8: If `irq_n[i]` is still high after `TIMEOUT_CYC` wait cycles, the run ends with error code 1. If `irq_n[i]` is seen low in the last wait cycle, the interrupt wins and the check proceeds.
- R9: Every access keeps `bus_addr`, `bus_wdata` and `bus_sel` constant for `SETUP_CYC` cycles with the strobe low, then for `PULSE_CYC` cycles with `bus_wr` (write) or `bus_rd` (read) high, then for `HOLD_CYC` cycles with the strobe low. Outside accesses the bus outputs are zero.
- R10: With `par_mode`=0 the whole sequence of R2 to R7 runs with `bus_sel`=01. It then runs again from R2 with `bus_sel`=10.
- R11: With `par_mode`=1, every write uses `bus_sel`=11, with two exceptions. The channel word goes first to `bus_sel`=01 and then to `bus_sel`=10. The wait and the two reads of R6 and R7 run for instance 0 with `bus_sel`=01 and then for instance 1 with `bus_sel`=10.
- R12: An error stops the bus at once, and `done`=1, `err`=1 and the code are held until the next `start`. `start` is ignored while a run is in progress. `par_mode` is sampled only together with `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or done |
| par_mode | input | 1 | 1 = both instances in parallel, 0 = one after the other |
| irq_n | input | 2 | Active-low interrupt line of each instance |
| rom_addr | output | ROM_AW | Word address into the firmware/parameter source |
| rom_data | input | 32 | Word at `rom_addr`, combinational |
| bus_addr | output | 4 | Register address of the current access |
| bus_wdata | output | 32 | Write data of the current access |
| bus_sel | output | 2 | Instance select, one bit per instance |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 32 | Read data, sampled in the last strobe cycle |
| done | output | 1 | Run finished, with or without error |
| err | output | 1 | Run finished with error |
| err_code | output | 2 | 1 timeout, 2 status bit missing, 3 wrong tag |

## Verification
The interrupt arriving and the wait timeout expiring can fall in the same cycle. The bench provokes this by pulling `irq_n` low exactly in the final permitted wait cycle. It then expects the status read to follow immediately, with no error code. A neighbouring run leaves the line high one cycle longer and must end with code 1. A second collision is a `start` pulse in the middle of a parallel run; the reference model requires that the access stream continue exactly as if the pulse had never happened.

// File: rtl/codec_boot_seq.sv
module codec_boot_seq #(
  parameter int FW_WORDS    = 8,
  parameter int PRM_WORDS   = 3,
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 2,
  parameter int HOLD_CYC    = 1,
  parameter int TIMEOUT_CYC = 4096,
  parameter logic [31:0] PLL_CFG    = 32'h0000_0084,
  parameter logic [31:0] CHAN_WORD0 = 32'h0201_0503,
  parameter logic [31:0] CHAN_WORD1 = 32'h0301_0503,
  localparam int ROM_AW = $clog2(FW_WORDS + PRM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              par_mode,
  input  logic [1:0]        irq_n,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [31:0]       rom_data,
  output logic [3:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  output logic [1:0]        bus_sel,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [31:0]       bus_rdata,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);
  localparam int PMAX = (SETUP_CYC > PULSE_CYC) ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                                                : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int PCW  = $clog2(PMAX + 1);
  localparam int WMAX = (FW_WORDS > PRM_WORDS) ? FW_WORDS : PRM_WORDS;
  localparam int IW   = $clog2(WMAX + 1);
  localparam int TW   = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [4:0] {
    S_IDLE, S_PLL, S_BOOT1, S_BUS1, S_MM1, S_IA1, S_FW, S_BOOT2, S_BUS2, S_MM2,
    S_IA2, S_CHAN, S_PRM, S_COMMIT, S_IEN, S_WAIT, S_FLG, S_ID, S_DONE
  } step_t;

  step_t          st;
  logic [1:0]     ph;
  logic [PCW-1:0] pc;
  logic [IW-1:0]  idx;
  logic [TW-1:0]  tmo;
  logic           cur, par, ok;

  wire            xact  = !(st inside {S_IDLE, S_WAIT, S_DONE});
  wire            is_rd = st inside {S_FLG, S_ID};
  wire [PCW-1:0]  lim   = (ph == 2'd0) ? PCW'(SETUP_CYC) : (ph == 2'd1) ? PCW'(PULSE_CYC) : PCW'(HOLD_CYC);
  wire            last  = (pc == lim - PCW'(1));
  wire            fin   = xact && (ph == 2'd2) && last;
  wire [1:0]      own   = cur ? 2'b10 : 2'b01;

  assign bus_wr   = xact && (ph == 2'd1) && !is_rd;
  assign bus_rd   = xact && (ph == 2'd1) && is_rd;
  assign bus_sel  = !xact ? 2'b00 : (par && !(st inside {S_CHAN, S_FLG, S_ID})) ? 2'b11 : own;
  assign rom_addr = (st == S_PRM) ? ROM_AW'(FW_WORDS) + ROM_AW'(idx) : ROM_AW'(idx);
  assign done     = (st == S_DONE);

  always_comb begin
    bus_addr  = 4'd0;
    bus_wdata = 32'h0;
    case (st)
      S_PLL:          begin bus_addr = 4'd0; bus_wdata = PLL_CFG; end
      S_BOOT1:        begin bus_addr = 4'd1; bus_wdata = 32'h0000_008A; end
      S_BOOT2:        begin bus_addr = 4'd1; bus_wdata = 32'h0000_008D; end
      S_BUS1, S_BUS2: begin bus_addr = 4'd2; bus_wdata = 32'h0000_000A; end
      S_MM1, S_MM2:   begin bus_addr = 4'd3; bus_wdata = 32'h0000_000A; end
      S_IA1:          begin bus_addr = 4'd4; bus_wdata = 32'h0005_0000; end
      S_IA2:          begin bus_addr = 4'd4; bus_wdata = 32'h0005_7F00; end
      S_FW, S_PRM:    begin bus_addr = 4'd5; bus_wdata = rom_data; end
      S_CHAN:         begin bus_addr = 4'd5; bus_wdata = cur ? CHAN_WORD1 : CHAN_WORD0; end
      S_COMMIT:       begin bus_addr = 4'd5; bus_wdata = 32'h0; end
      S_IEN:          begin bus_addr = 4'd6; bus_wdata = 32'h0000_0400; end
      S_FLG:          bus_addr = 4'd7;
      S_ID:           bus_addr = 4'd8;
      default:        ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; pc <= '0; idx <= '0; tmo <= '0;
      cur <= 1'b0; par <= 1'b0; ok <= 1'b0; err <= 1'b0; err_code <= '0;
    end else if (st == S_IDLE || st == S_DONE) begin
      if (start) begin
        st <= S_PLL; par <= par_mode; cur <= 1'b0; err <= 1'b0; err_code <= '0;
        ph <= '0; pc <= '0; idx <= '0; tmo <= '0;
      end
    end else if (st == S_WAIT) begin
      if (!irq_n[cur]) begin
        st <= S_FLG; tmo <= '0;
      end else if (tmo == TW'(TIMEOUT_CYC - 1)) begin
        st <= S_DONE; err <= 1'b1; err_code <= 2'd1;
      end else tmo <= tmo + TW'(1);
    end else begin
      if (last) begin
        pc <= '0;
        ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      end else pc <= pc + PCW'(1);
      if (ph == 2'd1 && last)
        ok <= (st == S_FLG) ? bus_rdata[10] : (bus_rdata == 32'h0000_FF82);
      if (fin) begin
        case (st)
          S_FW:
            if (idx == IW'(FW_WORDS - 1)) begin idx <= '0; st <= S_BOOT2; end
            else idx <= idx + IW'(1);
          S_CHAN:
            if (par && !cur) cur <= 1'b1;
            else begin cur <= par ? 1'b0 : cur; st <= S_PRM; end
          S_PRM:
            if (idx == IW'(PRM_WORDS - 1)) begin idx <= '0; st <= S_COMMIT; end
            else idx <= idx + IW'(1);
          S_FLG:
            if (!ok) begin st <= S_DONE; err <= 1'b1; err_code <= 2'd2; end
            else st <= S_ID;
          S_ID:
            if (!ok) begin st <= S_DONE; err <= 1'b1; err_code <= 2'd3; end
            else if (!cur) begin cur <= 1'b1; st <= par ? S_WAIT : S_PLL; end
            else st <= S_DONE;
          default: st <= step_t'(st + 5'd1);
        endcase
      end
    end
  end
endmodule

// File: rtl/codec_boot_seq_chk.sv
module codec_boot_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [1:0]  bus_sel,
  input logic        done,
  input logic        err
);
  AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_sel))
    else $error("write strobe rose without stable setup"); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr) |-> $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_sel))
    else $error("write strobe fell without hold"); // R9
  AST_RD_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> $stable(bus_addr) && $stable(bus_sel))
    else $error("read strobe rose without stable setup"); // R9
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> $countones(bus_sel) == 1)
    else $error("read addressed to more than one instance"); // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_wr && !bus_rd && bus_sel == 2'b00)
    else $error("bus active after completion"); // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done)
    else $error("error flag without completion"); // R12
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done)
    else $error("completion dropped without start"); // R12
endmodule

bind codec_boot_seq codec_boot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sel(bus_sel), .done(done), .err(err)
);

// File: tb/codec_boot_seq_test.sv
module codec_boot_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW  = 4;
  localparam int PRM = 2;
  localparam int SU  = 2;
  localparam int PW  = 3;
  localparam int HD  = 1;
  localparam int TMO = 20;
  localparam logic [31:0] PLL = 32'h0000_0084;
  localparam logic [31:0] CH0 = 32'h0201_0503;
  localparam logic [31:0] CH1 = 32'h0301_0503;
  localparam int ROM_AW = $clog2(FW + PRM);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, par_mode = 1'b0;
  logic [1:0] irq_n = 2'b11;
  logic [ROM_AW-1:0] rom_addr;
  logic [31:0] rom_data, bus_wdata, bus_rdata;
  logic [3:0] bus_addr;
  logic [1:0] bus_sel, err_code;
  logic bus_wr, bus_rd, done, err;

  logic [31:0] flg [2];
  logic [31:0] aid [2];
  int drop [2];

  int checks = 0, fails = 0, wd = 0;
  logic [45:0] q [$];
  string qt [$];
  logic [3:0] fin;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] romw(input int a);
    return 32'hC0DE_0000 + 32'(a) * 32'h0001_0101;
  endfunction

  assign rom_data = romw(int'(rom_addr));

  always_comb begin
    int i;
    i = (bus_sel == 2'b10) ? 1 : 0;
    if (bus_addr == 4'd7) bus_rdata = flg[i];
    else if (bus_addr == 4'd8) bus_rdata = aid[i];
    else bus_rdata = 32'hDEAD_BEEF;
  end

  codec_boot_seq #(
    .FW_WORDS(FW), .PRM_WORDS(PRM), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD),
    .TIMEOUT_CYC(TMO), .PLL_CFG(PLL), .CHAN_WORD0(CH0), .CHAN_WORD1(CH1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .par_mode(par_mode), .irq_n(irq_n),
    .rom_addr(rom_addr), .rom_data(rom_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .done(done), .err(err), .err_code(err_code)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  function automatic logic [45:0] mk(input logic [1:0] dr, input logic [1:0] s, input logic w,
                                      input logic r, input logic [3:0] a, input logic [31:0] d);
    return {dr, 1'b0, 1'b0, 2'b00, s, w, r, a, d};
  endfunction

  task automatic compare(input logic [43:0] e, input string t);
    logic [43:0] got;
    got = {done, err, err_code, bus_sel, bus_wr, bus_rd, bus_addr, bus_wdata};
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, got, e);
    end
  endtask

  task automatic push(input string t, input logic [1:0] s, input bit rd, input logic [3:0] a,
                      input logic [31:0] d);
    repeat (SU) begin q.push_back(mk(2'b00, s, 1'b0, 1'b0, a, d)); qt.push_back(t); end
    repeat (PW) begin q.push_back(mk(2'b00, s, !rd, rd, a, d)); qt.push_back(t); end
    repeat (HD) begin q.push_back(mk(2'b00, s, 1'b0, 1'b0, a, d)); qt.push_back(t); end
  endtask

  task automatic push_wait(input int inst, input int at, output bit hit);
    int n;
    string t;
    hit = (at >= 0 && at < TMO);
    n = hit ? at + 1 : TMO;
    t = (at >= TMO - 1 || at < 0) ? "R8" : "R6";
    for (int i = 0; i < n; i++) begin
      q.push_back(mk((hit && i == at) ? (inst ? 2'b10 : 2'b01) : 2'b00, 2'b00, 1'b0, 1'b0, 4'd0, 32'h0));
      qt.push_back(t);
    end
  endtask

  task automatic build(input bit par);
    string p;
    bit hit;
    p = par ? "R11/" : "R10/";
    fin = 4'b1000;
    for (int pass = 0; pass < (par ? 1 : 2); pass++) begin
      logic [1:0] s;
      s = par ? 2'b11 : (pass != 0 ? 2'b10 : 2'b01);
      push({p, "R2"}, s, 0, 4'd0, PLL);
      push({p, "R2"}, s, 0, 4'd1, 32'h8A);
      push({p, "R2"}, s, 0, 4'd2, 32'hA);
      push({p, "R2"}, s, 0, 4'd3, 32'hA);
      push({p, "R3"}, s, 0, 4'd4, 32'h0005_0000);
      for (int k = 0; k < FW; k++) push({p, "R3"}, s, 0, 4'd5, romw(k));
      push({p, "R4"}, s, 0, 4'd1, 32'h8D);
      push({p, "R4"}, s, 0, 4'd2, 32'hA);
      push({p, "R4"}, s, 0, 4'd3, 32'hA);
      push({p, "R5"}, s, 0, 4'd4, 32'h0005_7F00);
      if (par) begin
        push({p, "R5"}, 2'b01, 0, 4'd5, CH0);
        push({p, "R5"}, 2'b10, 0, 4'd5, CH1);
      end else push({p, "R5"}, s, 0, 4'd5, pass != 0 ? CH1 : CH0);
      for (int k = 0; k < PRM; k++) push({p, "R5"}, s, 0, 4'd5, romw(FW + k));
      push({p, "R5"}, s, 0, 4'd5, 32'h0);
      push({p, "R6"}, s, 0, 4'd6, 32'h400);
      for (int i = (par ? 0 : pass); i <= (par ? 1 : pass); i++) begin
        logic [1:0] oh;
        oh = (i != 0) ? 2'b10 : 2'b01;
        push_wait(i, drop[i], hit);
        if (!hit) begin fin = 4'b1101; return; end
        push({p, "R6"}, oh, 1, 4'd7, 32'h0);
        if (!flg[i][10]) begin fin = 4'b1110; return; end
        push({p, "R7"}, oh, 1, 4'd8, 32'h0);
        if (aid[i] != 32'h0000_FF82) begin fin = 4'b1111; return; end
      end
    end
  endtask

  task automatic run(input bit par, input int glitch, input string ftag);
    int cyc;
    logic [45:0] e;
    string t;
    irq_n = 2'b11;
    build(par);
    @(negedge clk);
    par_mode = par;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    par_mode = !par;
    cyc = 0;
    while (q.size() > 0) begin
      e = q.pop_front();
      t = qt.pop_front();
      compare(e[43:0], t);
      if (e[44]) irq_n[0] = 1'b0;
      if (e[45]) irq_n[1] = 1'b0;
      cyc++;
      start = (cyc == glitch);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) begin
      compare({fin, 40'h0}, ftag);
      @(negedge clk);
    end
  endtask

  initial begin
    flg[0] = 32'h0000_0400; flg[1] = 32'h0000_0400;
    aid[0] = 32'h0000_FF82; aid[1] = 32'h0000_FF82;
    repeat (3) begin @(negedge clk); compare(44'h0, "R1 in reset"); end
    rst_n = 1'b1;
    repeat (3) begin @(negedge clk); compare(44'h0, "R1 idle"); end

    drop[0] = 3; drop[1] = 0;
    run(1'b0, 0, "R10/R7 success");

    drop[0] = 5; drop[1] = 2;
    run(1'b1, 7, "R11/R12 success despite start mid-run");

    drop[0] = TMO - 1; drop[1] = 1;
    run(1'b0, 0, "R8 irq in last wait cycle wins");

    drop[0] = TMO; drop[1] = 1;
    run(1'b0, 0, "R8/R12 timeout code 1");

    drop[0] = 2; drop[1] = 2;
    flg[1] = 32'hFFFF_FBFF;
    run(1'b0, 0, "R6/R12 status bit clear code 2");
    flg[1] = 32'h0000_0400;

    drop[0] = 1; drop[1] = 1;
    aid[0] = 32'h0001_FF82;
    run(1'b1, 0, "R7/R12 wrong tag code 3");
    aid[0] = 32'h0000_FF82;

    drop[0] = 0; drop[1] = 4;
    run(1'b1, 0, "R11/R12 recovery after error");

    report();
    $finish;
  end
endmodule